// File: doc/BRIEF.md
# Page-Mode DRAM Controller with Interval Refresh

This controller sits between a simple processor-side request port and an asynchronous-style DRAM device. Each request carries a read/write flag, a word address and write data. The controller splits the address into a row part and a column part. It presents them one after the other on a single shared address bus, strobing the row with an active-low row strobe and then the column with an active-low column strobe. When the access has finished, it pulses `ready` for one clock.

After an access the row is left open. A following request to the same row is served with a column phase only, which removes the whole row phase from its latency. A request to a different row first closes the page: the row strobe goes high for a parameterised precharge time, and then the new row is opened.

A free-running interval timer schedules refresh. One refresh comes due every `REF_CYCLES` clocks; the default of 1562 corresponds to 15.625 µs at a 100 MHz clock. A due refresh waits until any access in flight has completed. It then closes an open page and runs a row-only refresh cycle on the next row of an internal counter. Any later access therefore starts with a full row phase.

Top module: `pgdram_ctrl`

## Requirements
- R1: The row part of a request is the upper `ROW_W` bits of `req_addr` and the column part is the lower `COL_W` bits. The row part is on `dram_addr` when `ras_n` falls, and the column part is on `dram_addr` when `cas_n` falls, both zero-extended to the bus width.
- R2: `cas_n` is low only while `ras_n` is low. `cas_n` falls at least `T_RCD` cycles after the `ras_n` fall that opened the row.
- R3: Every column phase holds `cas_n` low for exactly `T_CAS` cycles with `dram_addr` stable. For a write, `we_n` is low during the phase and `req_wdata` is driven on `dram_wdata`. For a read, `dram_rdata` is captured at the end of the phase.
- R4: Page hit latency. Count clock edges from the first edge that samples `req` high up to and including the edge that raises `ready`. A request to the open row takes `T_CAS+1` edges and produces no row-strobe fall. A request made while no row is open takes `T_RCD+T_CAS+1` edges.
- R5: Before `ras_n` falls, it has been high for at least `T_PRE` cycles. A request to a row other than the open one takes `T_PRE+T_RCD+T_CAS+2` edges, counted as in R4.
- R6: Refreshes start `REF_CYCLES` clocks apart. A start may move by no more than one access plus one page close. Each refresh holds `ras_n` low for exactly `T_RAS` cycles while `cas_n` stays high.
- R7: Successive refreshes drive row addresses 0, 1, 2 and so on, one higher each time, wrapping modulo 2^`ROW_W`.
- R8: A refresh never begins while an access is in progress: between its first column strobe and its `ready` pulse. A refresh starts only when both strobes are high.
- R9: A refresh that comes due while a row is open closes that row first. The next access, even to the same row, goes through a full row phase with the closed-page latency of R4.
- R10: `ready` is high for exactly one cycle per access and never while `cas_n` is low. `rd_data` returns the value last written to that address. After reset, `ready` is 0 and both strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access request, held stable until `ready` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row bits on top |
| req_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, valid with `ready` |
| ready | output | 1 | One-cycle completion pulse |
| dram_addr | output | max(ROW_W,COL_W) | Shared row/column address bus |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| dram_wdata | output | DATA_W | Data to the device |
| dram_rdata | input | DATA_W | Data from the device |

## Verification
The bound checker watches the strobe protocol on every cycle:
- the column strobe only inside a row-strobe window, and at least `T_RCD` after the row strobe fell;
- the precharge gap before every row-strobe fall;
- a stable address during the column strobe;
- a single-cycle `ready`;
- refresh starting only with both strobes high.

Only the bench's scenarios can show the rest:
- that data written reaches the right cell and reads back correctly;
- the hit, closed and miss latencies;
- that the refresh rows advance in order and at the right interval;
- that a refresh forces a fresh row phase on an otherwise-hitting request.

The bench needs a behavioural DRAM model and chosen request sequences to measure these.

// File: rtl/pgdram_pkg.sv
package pgdram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_DONE,
    ST_CLOSE,
    ST_REF,
    ST_RPRE
  } seq_st_e;

  // width of the shared address bus
  function automatic int unsigned bus_width(input int unsigned row_w, input int unsigned col_w);
    return (row_w > col_w) ? row_w : col_w;
  endfunction

  // bits needed to count 0..maxv-1
  function automatic int unsigned cnt_width(input int unsigned maxv);
    return (maxv < 2) ? 1 : $clog2(maxv);
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/pgdram_refresh_tmr.sv
module pgdram_refresh_tmr #(
  parameter int unsigned REF_CYCLES = 1562,
  parameter int unsigned ROW_W      = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_done,
  output logic             ref_pend,
  output logic [ROW_W-1:0] ref_row
);
  localparam int unsigned TW = pgdram_pkg::cnt_width(REF_CYCLES);

  logic [TW-1:0] tick_cnt;
  logic          tick;

  assign tick = (tick_cnt == '0);

  // free-running interval counter: a late refresh does not shift the schedule
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt <= TW'(REF_CYCLES - 1);
    end else if (tick) begin
      tick_cnt <= TW'(REF_CYCLES - 1);
    end else begin
      tick_cnt <= tick_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_pend <= 1'b0;
    end else if (tick) begin
      ref_pend <= 1'b1;
    end else if (ref_done) begin
      ref_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_row <= '0;
    end else if (ref_done) begin
      ref_row <= ref_row + 1'b1;
    end
  end

endmodule

// File: rtl/pgdram_page_trk.sv
module pgdram_page_trk #(
  parameter int unsigned ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_ev,
  input  logic             close_ev,
  input  logic [ROW_W-1:0] req_row,
  output logic             page_open,
  output logic [ROW_W-1:0] open_row,
  output logic             page_hit
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_open <= 1'b0;
      open_row  <= '0;
    end else if (close_ev) begin
      page_open <= 1'b0;
    end else if (open_ev) begin
      page_open <= 1'b1;
      open_row  <= req_row;
    end
  end

  assign page_hit = page_open && (req_row == open_row);

endmodule

// File: rtl/pgdram_seq.sv
module pgdram_seq
  import pgdram_pkg::*;
#(
  parameter int unsigned T_RCD = 2,
  parameter int unsigned T_CAS = 2,
  parameter int unsigned T_PRE = 2,
  parameter int unsigned T_RAS = 3
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req,
  input  logic    page_open,
  input  logic    page_hit,
  input  logic    ref_pend,
  output seq_st_e state,
  output logic    row_open_ev,
  output logic    page_close_ev,
  output logic    ref_start_ev,
  output logic    ref_done_ev,
  output logic    col_last
);
  localparam int unsigned MAXT = max4(T_RCD, T_CAS, T_PRE, T_RAS);
  localparam int unsigned CW   = cnt_width(MAXT + 1);

  logic [CW-1:0] cnt;
  seq_st_e       nxt;

  function automatic logic at_end(input logic [CW-1:0] c, input int unsigned t);
    return c == CW'(t - 1);
  endfunction

  always_comb begin
    nxt           = state;
    row_open_ev   = 1'b0;
    page_close_ev = 1'b0;
    ref_start_ev  = 1'b0;
    ref_done_ev   = 1'b0;
    col_last      = (state == ST_COL) && at_end(cnt, T_CAS);
    case (state)
      ST_IDLE: begin
        // refresh wins over a new request; it is only looked at here
        if (ref_pend) begin
          if (page_open) begin
            nxt           = ST_CLOSE;
            page_close_ev = 1'b1;
          end else begin
            nxt          = ST_REF;
            ref_start_ev = 1'b1;
          end
        end else if (req) begin
          if (page_hit) begin
            nxt = ST_COL;
          end else if (page_open) begin
            nxt           = ST_CLOSE;
            page_close_ev = 1'b1;
          end else begin
            nxt         = ST_ROW;
            row_open_ev = 1'b1;
          end
        end
      end
      ST_ROW:   if (at_end(cnt, T_RCD)) nxt = ST_COL;
      ST_COL:   if (col_last) nxt = ST_DONE;
      ST_DONE:  nxt = ST_IDLE;
      ST_CLOSE: if (at_end(cnt, T_PRE)) nxt = ST_IDLE;
      ST_REF:   if (at_end(cnt, T_RAS)) nxt = ST_RPRE;
      ST_RPRE: begin
        if (at_end(cnt, T_PRE)) begin
          nxt         = ST_IDLE;
          ref_done_ev = 1'b1;
        end
      end
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nxt;
      cnt   <= (nxt != state) ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pgdram_ctrl.sv
module pgdram_ctrl
  import pgdram_pkg::*;
#(
  parameter  int unsigned ROW_W      = 10,
  parameter  int unsigned COL_W      = 8,
  parameter  int unsigned DATA_W     = 16,
  parameter  int unsigned T_RCD      = 2,
  parameter  int unsigned T_CAS      = 2,
  parameter  int unsigned T_PRE      = 2,
  parameter  int unsigned T_RAS      = 3,
  parameter  int unsigned REF_CYCLES = 1562,
  localparam int unsigned AW         = ROW_W + COL_W,
  localparam int unsigned BW         = bus_width(ROW_W, COL_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic [AW-1:0]     req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              ready,
  output logic [BW-1:0]     dram_addr,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [DATA_W-1:0] dram_wdata,
  input  logic [DATA_W-1:0] dram_rdata
);

  function automatic logic [ROW_W-1:0] row_part(input logic [AW-1:0] a);
    return a[AW-1:COL_W];
  endfunction

  function automatic logic [COL_W-1:0] col_part(input logic [AW-1:0] a);
    return a[COL_W-1:0];
  endfunction

  seq_st_e          state;
  logic             page_open, page_hit;
  logic [ROW_W-1:0] open_row, ref_row, req_row;
  logic             ref_pend;
  logic             row_open, page_close, ref_start, ref_done, col_last;

  assign req_row = row_part(req_addr);

  pgdram_refresh_tmr #(
    .REF_CYCLES(REF_CYCLES),
    .ROW_W     (ROW_W)
  ) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_done(ref_done),
    .ref_pend(ref_pend),
    .ref_row (ref_row)
  );

  pgdram_page_trk #(
    .ROW_W(ROW_W)
  ) u_page (
    .clk      (clk),
    .rst_n    (rst_n),
    .open_ev  (row_open),
    .close_ev (page_close),
    .req_row  (req_row),
    .page_open(page_open),
    .open_row (open_row),
    .page_hit (page_hit)
  );

  pgdram_seq #(
    .T_RCD(T_RCD),
    .T_CAS(T_CAS),
    .T_PRE(T_PRE),
    .T_RAS(T_RAS)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req          (req),
    .page_open    (page_open),
    .page_hit     (page_hit),
    .ref_pend     (ref_pend),
    .state        (state),
    .row_open_ev  (row_open),
    .page_close_ev(page_close),
    .ref_start_ev (ref_start),
    .ref_done_ev  (ref_done),
    .col_last     (col_last)
  );

  // shared bus: column in the column phase, refresh row in refresh, else request row
  always_comb begin
    case (state)
      ST_COL:  dram_addr = BW'(col_part(req_addr));
      ST_REF:  dram_addr = BW'(ref_row);
      default: dram_addr = BW'(req_row);
    endcase
  end

  // the row strobe tracks the open page, so it stays low between hits
  assign ras_n      = !(page_open || (state == ST_REF));
  assign cas_n      = (state != ST_COL);
  assign we_n       = !((state == ST_COL) && req_we);
  assign dram_wdata = req_wdata;
  assign ready      = (state == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (col_last && !req_we) begin
      rd_data <= dram_rdata;
    end
  end

endmodule

// File: rtl/pgdram_ctrl_chk.sv
module pgdram_ctrl_chk #(
  parameter int unsigned T_RCD = 2,
  parameter int unsigned T_PRE = 2,
  parameter int unsigned BW    = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ras_n,
  input logic          cas_n,
  input logic [BW-1:0] dram_addr,
  input logic          ready,
  input logic          ref_start
);
  // cycles the row strobe has spent low / high, saturating
  logic [7:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= 8'(T_PRE);
    end else if (ras_n) begin
      lo_cnt <= '0;
      hi_cnt <= (hi_cnt == 8'hFF) ? hi_cnt : hi_cnt + 1'b1;
    end else begin
      hi_cnt <= '0;
      lo_cnt <= (lo_cnt == 8'hFF) ? lo_cnt : lo_cnt + 1'b1;
    end
  end

  // R2
  cas_in_row_chk: assert property (@(posedge clk) disable iff (!rst_n) !cas_n |-> !ras_n);

  // R2
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> (lo_cnt >= 8'(T_RCD)));

  // R5
  precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_cnt >= 8'(T_PRE)));

  // R3
  col_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && $past(!cas_n)) |-> $stable(dram_addr));

  // R10
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) ready |=> !ready);

  // R10
  ready_no_cas_chk: assert property (@(posedge clk) disable iff (!rst_n) ready |-> cas_n);

  // R8
  ref_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_start |-> (ras_n && cas_n));

endmodule

bind pgdram_ctrl pgdram_ctrl_chk #(
  .T_RCD(T_RCD),
  .T_PRE(T_PRE),
  .BW   (BW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ras_n    (ras_n),
  .cas_n    (cas_n),
  .dram_addr(dram_addr),
  .ready    (ready),
  .ref_start(ref_start)
);

// File: tb/pgdram_ctrl_tb.sv
module pgdram_ctrl_tb;
  localparam int CLK_NS = 10;
  localparam int ROW_W  = 3;
  localparam int COL_W  = 2;
  localparam int DW     = 8;
  localparam int T_RCD  = 2;
  localparam int T_CAS  = 2;
  localparam int T_PRE  = 2;
  localparam int T_RAS  = 3;
  localparam int REF    = 300;
  localparam int AW     = ROW_W + COL_W;
  localparam int NW     = 1 << AW;
  localparam int BW     = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int LAT_HIT    = T_CAS + 1;
  localparam int LAT_CLOSED = T_RCD + T_CAS + 1;
  localparam int LAT_MISS   = T_PRE + T_RCD + T_CAS + 2;
  localparam int SLACK      = T_RCD + T_CAS + T_PRE + 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] rd_data, dram_wdata, dram_rdata;
  logic          ready, ras_n, cas_n, we_n;
  logic [BW-1:0] dram_addr;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pgdram_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DW), .T_RCD(T_RCD), .T_CAS(T_CAS),
    .T_PRE(T_PRE), .T_RAS(T_RAS), .REF_CYCLES(REF)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .rd_data(rd_data), .ready(ready), .dram_addr(dram_addr),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .dram_wdata(dram_wdata),
    .dram_rdata(dram_rdata)
  );

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int s);
    return DW'(a * 37 + s * 11 + 5);
  endfunction

  // ---------------- behavioural DRAM device, sampled mid-cycle ----------------
  logic [DW-1:0]    mem [NW];
  logic [ROW_W-1:0] lrow = '0, exp_ref_row = '0;
  logic [COL_W-1:0] lcol = '0;
  bit prev_ras = 1, prev_cas = 1, cas_in_win = 0, outstanding = 0;
  int rise_cyc = -1000, fall_cyc = 0, cas_fall_cyc = 0, last_ref = 0;
  int ref_n = 0, ras_falls = 0;
  int cur_addr = 0;
  logic [DW-1:0] cur_wdata = '0;

  assign dram_rdata = mem[{lrow, lcol}];

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_ras && !ras_n) begin
        chk(cyc - rise_cyc >= T_PRE, "R5 precharge before row strobe", cyc - rise_cyc, T_PRE);
        chk(!outstanding, "R8 refresh/row start during access", outstanding, 0);
        lrow = dram_addr[ROW_W-1:0];
        fall_cyc = cyc;
        cas_in_win = 0;
        ras_falls++;
      end
      if (!prev_ras && ras_n) begin
        if (!cas_in_win) begin
          chk(lrow == exp_ref_row, "R7 refresh row order", lrow, exp_ref_row);
          exp_ref_row = exp_ref_row + 1'b1;
          chk(cyc - fall_cyc == T_RAS, "R6 refresh strobe width", cyc - fall_cyc, T_RAS);
          if (ref_n > 0)
            chk((fall_cyc - last_ref >= REF - SLACK) && (fall_cyc - last_ref <= REF + SLACK),
                "R6 refresh interval", fall_cyc - last_ref, REF);
          last_ref = fall_cyc;
          ref_n++;
        end
        rise_cyc = cyc;
      end
      if (prev_cas && !cas_n) begin
        chk(!ras_n && (cyc - fall_cyc >= T_RCD), "R2 column after row hold",
            cyc - fall_cyc, T_RCD);
        lcol = dram_addr[COL_W-1:0];
        chk({lrow, lcol} == AW'(cur_addr), "R1 row/column split", {lrow, lcol}, cur_addr);
        if (!we_n) begin
          chk(dram_wdata == cur_wdata, "R3 write data", dram_wdata, cur_wdata);
          mem[{lrow, lcol}] = dram_wdata;
        end
        cas_fall_cyc = cyc;
        cas_in_win = 1;
        outstanding = 1;
      end
      if (!prev_cas && cas_n)
        chk(cyc - cas_fall_cyc == T_CAS, "R3 column strobe width", cyc - cas_fall_cyc, T_CAS);
      if (ready) outstanding = 0;
      prev_ras = ras_n;
      prev_cas = cas_n;
    end
  end

  // ---------------- request driver ----------------
  task automatic do_acc(input bit we, input int a, input logic [DW-1:0] wd,
                        output logic [DW-1:0] rd, output int lat);
    @(negedge clk);
    req = 1; req_we = we; req_addr = AW'(a); req_wdata = wd;
    cur_addr = a; cur_wdata = wd;
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end while (!ready && lat < 1000);
    rd = rd_data;
    req = 0;
    @(negedge clk);
    chk(!ready, "R10 ready single cycle", ready, 0);
  endtask

  task automatic wait_ref();
    int n0 = ref_n;
    while (ref_n == n0) @(negedge clk);
    repeat (T_PRE + 2) @(negedge clk);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (R10) actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd;
    int lat, f0;
    for (int i = 0; i < NW; i++) mem[i] = '0;
    repeat (5) @(negedge clk);
    // R10: reset state
    chk(ras_n == 1 && cas_n == 1 && ready == 0, "R10 reset strobes/ready",
        {ras_n, cas_n, ready}, 3'b110);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R4: first access with no row open, then a hit
    do_acc(1, 0, pat(0, 0), rd, lat);
    chk(lat == LAT_CLOSED, "R4 closed-page latency", lat, LAT_CLOSED);
    f0 = ras_falls;
    do_acc(1, 1, pat(1, 0), rd, lat);
    chk(lat == LAT_HIT, "R4 page-hit latency", lat, LAT_HIT);
    chk(ras_falls == f0, "R4 no row phase on hit", ras_falls, f0);

    // R10/R1: row-major fill and readback
    for (int a = 2; a < NW; a++) do_acc(1, a, pat(a, 0), rd, lat);
    for (int a = 0; a < NW; a++) begin
      do_acc(0, a, '0, rd, lat);
      chk(rd == pat(a, 0), "R10 readback row-major", rd, pat(a, 0));
    end
    // strided reads that hop rows
    for (int i = 0; i < NW; i++) begin
      int a = (i * 5) % NW;
      do_acc(0, a, '0, rd, lat);
      chk(rd == pat(a, 0), "R10 readback strided", rd, pat(a, 0));
    end
    // R5: column-major rewrite (every access changes row)
    for (int c = 0; c < (1 << COL_W); c++)
      for (int r = 0; r < (1 << ROW_W); r++)
        do_acc(1, (r << COL_W) | c, pat((r << COL_W) | c, 1), rd, lat);
    for (int a = NW - 1; a >= 0; a--) begin
      do_acc(0, a, '0, rd, lat);
      chk(rd == pat(a, 1), "R10 readback after column-major write", rd, pat(a, 1));
    end

    // latencies in a refresh-free window
    wait_ref();
    f0 = ras_falls;
    do_acc(0, 9, '0, rd, lat);
    chk(lat == LAT_CLOSED, "R9 access after refresh takes row phase", lat, LAT_CLOSED);
    chk(ras_falls == f0 + 1, "R9 row strobe after refresh", ras_falls, f0 + 1);
    chk(rd == pat(9, 1), "R10 data after refresh", rd, pat(9, 1));
    do_acc(0, 10, '0, rd, lat);
    chk(lat == LAT_HIT, "R4 hit latency", lat, LAT_HIT);
    do_acc(0, 21, '0, rd, lat);
    chk(lat == LAT_MISS, "R5 page-miss latency", lat, LAT_MISS);
    chk(rd == pat(21, 1), "R5 data after miss", rd, pat(21, 1));

    // R9: open row, let refresh close it, same row again
    wait_ref();
    f0 = ras_falls;
    do_acc(0, 22, '0, rd, lat);
    chk(lat == LAT_CLOSED, "R9 same row after refresh is not a hit", lat, LAT_CLOSED);
    chk(ras_falls == f0 + 1, "R9 fresh row strobe", ras_falls, f0 + 1);

    // R6/R7: idle refreshes
    repeat (3 * REF) @(negedge clk);
    chk(ref_n >= cyc / REF - 1, "R6 refresh count", ref_n, cyc / REF - 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule